// File: doc/BRIEF.md
# Pipelined Unsigned Integer Divider

This block divides an unsigned numerator by an unsigned denominator and returns both the quotient and the remainder. The two operands have widths that are set separately. The quotient is built by a chain of restoring-division stages, and each stage decides one quotient bit, the most significant bit first. Each stage shifts the next numerator bit into a partial remainder. When that value is at least the denominator, the stage subtracts the denominator and sets its quotient bit. The partial remainder left after the last stage is the remainder.

A latency parameter sets how many register ranks are cut into the chain. A value of zero gives a purely combinational divider. A placement parameter chooses the stage at which the ranks begin. A minimum-denominator-width parameter states a lower bound on the denominator. The chain then drops the top quotient stages, which can never produce a one. Every rank shares one clock enable and one asynchronous active-low clear. Because of this, a held enable freezes every operand in flight, and a clear empties the whole chain at once.

Top module: `pdiv_top`

## Requirements
- R1: When the denominator is at least 2^(DMIN_W-1), and is not zero, the quotient equals floor(num/den) and the remainder equals num mod den.
- R2: The quotient is Q_W = N_W - DMIN_W + 1 bits wide and the remainder is min(N_W, D_W) bits wide. The largest quotient that fits, all Q_W bits set, is produced exactly.
- R3: A zero denominator, allowed only when DMIN_W is 1, gives a quotient with every bit set and a remainder equal to the low min(N_W, D_W) bits of the numerator.
- R4: With LAT = 0 the outputs follow the operands in the same cycle, whatever the clock enable or the clock is doing.
- R5: With LAT > 0, an operand pair sampled on a rising edge with the enable high shows at the outputs after exactly LAT such enabled rising edges. A new pair is accepted on every enabled edge.
- R6: While the enable is low, no register changes on a rising edge. The operands presented during those edges are never captured, and the results that follow keep their order.
- R7: A low clear forces every pipeline register to zero at once, without waiting for a clock edge. When PLACE = 0, the last rank sits at the outputs, so quotient and remainder read zero during the clear.
- R8: The ranks start at stage Q_W-1-PLACE, counting the first stage as 0. If they would run past the last stage, they are moved back so that they end on it. The placement changes neither the latency nor any result.
- R9: With DMIN_W > 1, every denominator in the range 2^(DMIN_W-1) to 2^D_W-1 gives the correct result of R1 on the reduced quotient width, including numerators whose top bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register ranks |
| clr_n | input | 1 | Asynchronous clear, active low, empties all ranks |
| en | input | 1 | Clock enable for all ranks, high to advance |
| num | input | N_W | Unsigned numerator |
| den | input | D_W | Unsigned denominator |
| quo | output | Q_W | Quotient |
| rem | output | min(N_W, D_W) | Remainder |

## Verification
The clock enable can drop in the same cycle that a fresh operand pair is presented. A held edge must then freeze the pairs already in flight and must also refuse the new one. The bench provokes this with a stall pattern that lowers the enable on every third cycle, while it keeps changing the operands on all cycles. It judges the outcome by matching each result, in order, against only those pairs that were offered on enabled edges. A second overlap comes from the clear, which is dropped between clock edges while results are still in flight. Register-at-output outputs must read zero at once, and the ordered matching must start again cleanly afterwards.

// File: rtl/pdiv_pkg.sv
// Shared helpers for the pipelined divider.
// Assumes: the rank placement is a pure function of the parameters.
package pdiv_pkg;

    // True when a register rank follows the given stage (stage 0 is the first one).
    function automatic bit rank_after(int stage, int qw, int lat, int place);
        int first;
        first = qw - 1 - place;
        if (first > qw - lat) first = qw - lat;
        if (first < 0) first = 0;
        return (lat > 0) && (stage >= first) && (stage < first + lat);
    endfunction

endpackage

// File: rtl/pdiv_stage.sv
// One restoring-division step: it brings in numerator bit BIT and decides quotient bit BIT.
// Assumes: pr_in < d_in whenever d_in is nonzero, so the new partial remainder fits in D_W bits.
module pdiv_stage #(
    parameter int N_W = 8,
    parameter int D_W = 8,
    parameter int Q_W = 8,
    parameter int BIT = 0
) (
    input  logic [D_W-1:0] pr_in,
    input  logic [D_W-1:0] d_in,
    input  logic [N_W-1:0] n_in,
    input  logic [Q_W-1:0] q_in,
    output logic [D_W-1:0] pr_out,
    output logic [D_W-1:0] d_out,
    output logic [N_W-1:0] n_out,
    output logic [Q_W-1:0] q_out
);

    logic [D_W:0] trial;
    logic [D_W:0] diff;
    logic [D_W:0] pick;
    logic         ge;

    // Trial subtraction of the denominator from the shifted partial remainder.
    always_comb begin : p_step
        trial = {pr_in, n_in[BIT]};
        ge    = trial >= {1'b0, d_in};
        diff  = trial - {1'b0, d_in};
        pick  = ge ? diff : trial;
    end

    assign pr_out = pick[D_W-1:0];
    assign d_out  = d_in;
    assign n_out  = n_in;
    assign q_out  = q_in | (Q_W'(ge) << BIT);

    // The kept partial remainder must stay below the denominator's range.
    always_comb begin : p_check
        assert_stage_fits_R1: assert (d_in == '0 || pick[D_W] == 1'b0)
            else $error("partial remainder overflowed D_W bits");
    end

endmodule

// File: rtl/pdiv_rank.sv
// One register rank of the divider chain: it has an asynchronous clear and a shared clock enable.
// Assumes: clr_n is active low; en high lets the rank load.
module pdiv_rank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Load the stage state when enabled, or clear it at once.
    always_ff @(posedge clk or negedge clr_n) begin : p_hold
        if (!clr_n) q <= '0;
        else if (en) q <= d;
    end

    assert_rank_holds_R6: assert property (@(posedge clk) disable iff (!clr_n)
        !en |=> $stable(q))
        else $error("rank moved while enable was low");

    assert_rank_cleared_R7: assert property (@(posedge clk)
        !clr_n |-> (q == '0))
        else $error("rank not zero during clear");

endmodule

// File: rtl/pdiv_top.sv
// Pipelined unsigned divider: a chain of Q_W restoring stages with LAT register ranks.
// The ranks begin at stage Q_W-1-PLACE and are moved back if they would run past the end.
// Assumes: den >= 2^(DMIN_W-1) (zero is allowed only when DMIN_W = 1), 1 <= DMIN_W <= min(N_W, D_W), LAT <= Q_W.
module pdiv_top #(
    parameter int N_W    = 8,
    parameter int D_W    = 8,
    parameter int DMIN_W = 1,
    parameter int LAT    = 0,
    parameter int PLACE  = (N_W - DMIN_W + 1) / 2,
    localparam int Q_W   = N_W - DMIN_W + 1,
    localparam int R_W   = (N_W < D_W) ? N_W : D_W
) (
    input  logic           clk,
    input  logic           clr_n,
    input  logic           en,
    input  logic [N_W-1:0] num,
    input  logic [D_W-1:0] den,
    output logic [Q_W-1:0] quo,
    output logic [R_W-1:0] rem
);

    localparam int SW = 2 * D_W + N_W + Q_W;
    localparam int PW = Q_W + D_W + N_W;
    localparam logic [D_W-1:0] DLOW = D_W'(1) << (DMIN_W - 1);

    logic [D_W-1:0] pr_c [0:Q_W];
    logic [D_W-1:0] d_c  [0:Q_W];
    logic [N_W-1:0] n_c  [0:Q_W];
    logic [Q_W-1:0] q_c  [0:Q_W];

    // The starting partial remainder holds the numerator bits above the quotient range.
    if (DMIN_W > 1) begin : g_init_hi
        assign pr_c[0] = D_W'(num[N_W-1:Q_W]);
    end else begin : g_init_zero
        assign pr_c[0] = '0;
    end
    assign d_c[0] = den;
    assign n_c[0] = num;
    assign q_c[0] = '0;

    for (genvar i = 0; i < Q_W; i++) begin : g_stage
        logic [D_W-1:0] s_pr;
        logic [D_W-1:0] s_d;
        logic [N_W-1:0] s_n;
        logic [Q_W-1:0] s_q;

        pdiv_stage #(.N_W(N_W), .D_W(D_W), .Q_W(Q_W), .BIT(Q_W - 1 - i)) u_stage (
            .pr_in (pr_c[i]),
            .d_in  (d_c[i]),
            .n_in  (n_c[i]),
            .q_in  (q_c[i]),
            .pr_out(s_pr),
            .d_out (s_d),
            .n_out (s_n),
            .q_out (s_q)
        );

        if (pdiv_pkg::rank_after(i, Q_W, LAT, PLACE)) begin : g_rank
            logic [SW-1:0] r_q;
            pdiv_rank #(.W(SW)) u_rank (
                .clk  (clk),
                .clr_n(clr_n),
                .en   (en),
                .d    ({s_pr, s_d, s_n, s_q}),
                .q    (r_q)
            );
            assign {pr_c[i+1], d_c[i+1], n_c[i+1], q_c[i+1]} = r_q;
        end else begin : g_wire
            assign pr_c[i+1] = s_pr;
            assign d_c[i+1]  = s_d;
            assign n_c[i+1]  = s_n;
            assign q_c[i+1]  = s_q;
        end
    end

    assign quo = q_c[Q_W];
    assign rem = pr_c[Q_W][R_W-1:0];

    // Rebuild the numerator from the outputs and the operands carried along the chain.
    logic [PW-1:0] recon;
    always_comb begin : p_recon
        recon = PW'(q_c[Q_W]) * PW'(d_c[Q_W]) + PW'(pr_c[Q_W]);
    end

    assert_quot_identity_R1: assert property (@(posedge clk) disable iff (!clr_n)
        (d_c[Q_W] >= DLOW) |-> (recon == PW'(n_c[Q_W])))
        else $error("quotient*den+rem differs from numerator");

    assert_rem_below_den_R1: assert property (@(posedge clk) disable iff (!clr_n)
        (d_c[Q_W] >= DLOW) |-> (D_W'(rem) < d_c[Q_W]))
        else $error("remainder not below denominator");

    if (LAT == 0) begin : g_comb_chk
        assert_comb_still_R4: assert property (@(posedge clk) disable iff (!clr_n)
            (!en && $stable(num) && $stable(den)) |-> ($stable(quo) && $stable(rem)))
            else $error("combinational outputs moved with steady operands");
    end

endmodule

// File: tb/pdiv_top_tb.sv
`timescale 1ns/1ps
// Directed bench: five divider configurations are driven side by side and checked in order.
module pdiv_top_tb;

    logic clk = 1'b0;
    logic clr_n = 1'b1;
    logic en = 1'b0;
    logic [7:0] n8 = '0, d8 = '0;
    logic [9:0] n10 = '0;
    logic [5:0] d6 = 6'd16;
    logic [5:0] n6 = '0;
    logic [8:0] d9 = '0;

    logic [7:0] qa, ra, qb, rb, qc, rc;
    logic [5:0] qd, rd, qe, re;

    int checks = 0;
    int errors = 0;
    int idx = 0;
    longint h8n [0:1023];
    longint h8d [0:1023];
    longint h10n [0:1023];
    longint h6d [0:1023];
    longint h6n [0:1023];
    longint h9d [0:1023];

    always #4 clk = ~clk;

    // A: mid placement, B: combinational, C: ranks at the outputs, D: denominator floor, E: full latency.
    pdiv_top #(.N_W(8), .D_W(8), .DMIN_W(1), .LAT(3)) u_dut (
        .clk(clk), .clr_n(clr_n), .en(en), .num(n8), .den(d8), .quo(qa), .rem(ra));
    pdiv_top #(.N_W(8), .D_W(8), .DMIN_W(1), .LAT(0)) u_dut_b (
        .clk(clk), .clr_n(clr_n), .en(en), .num(n8), .den(d8), .quo(qb), .rem(rb));
    pdiv_top #(.N_W(8), .D_W(8), .DMIN_W(1), .LAT(2), .PLACE(0)) u_dut_c (
        .clk(clk), .clr_n(clr_n), .en(en), .num(n8), .den(d8), .quo(qc), .rem(rc));
    pdiv_top #(.N_W(10), .D_W(6), .DMIN_W(5), .LAT(4), .PLACE(5)) u_dut_d (
        .clk(clk), .clr_n(clr_n), .en(en), .num(n10), .den(d6), .quo(qd), .rem(rd));
    pdiv_top #(.N_W(6), .D_W(9), .DMIN_W(1), .LAT(6)) u_dut_e (
        .clk(clk), .clr_n(clr_n), .en(en), .num(n6), .den(d9), .quo(qe), .rem(re));

    function automatic longint exp_q(longint n, longint d, int qw);
        if (d == 0) return (longint'(1) << qw) - 1;
        return n / d;
    endfunction

    function automatic longint exp_r(longint n, longint d, int rw);
        if (d == 0) return n & ((longint'(1) << rw) - 1);
        return n % d;
    endfunction

    task automatic cmp(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One cycle: check the results now due, then present new operands at the falling edge.
    task automatic step(input string tag, input bit enable,
                        input longint an, input longint ad, input longint dn, input longint dd,
                        input longint xn, input longint xd);
        @(negedge clk);
        if (idx >= 3) begin
            cmp(tag, "A quo", qa, exp_q(h8n[idx-3], h8d[idx-3], 8));
            cmp(tag, "A rem", ra, exp_r(h8n[idx-3], h8d[idx-3], 8));
        end
        if (idx >= 2) begin
            cmp(tag, "C quo", qc, exp_q(h8n[idx-2], h8d[idx-2], 8));
            cmp(tag, "C rem", rc, exp_r(h8n[idx-2], h8d[idx-2], 8));
        end
        if (idx >= 4) begin
            cmp(tag, "D quo", qd, exp_q(h10n[idx-4], h6d[idx-4], 6));
            cmp(tag, "D rem", rd, exp_r(h10n[idx-4], h6d[idx-4], 6));
        end
        if (idx >= 6) begin
            cmp(tag, "E quo", qe, exp_q(h6n[idx-6], h9d[idx-6], 6));
            cmp(tag, "E rem", re, exp_r(h6n[idx-6], h9d[idx-6], 6));
        end
        en  = enable;
        n8  = an[7:0];
        d8  = ad[7:0];
        n10 = dn[9:0];
        d6  = dd[5:0];
        n6  = xn[5:0];
        d9  = xd[8:0];
        if (enable) begin
            h8n[idx] = an; h8d[idx] = ad;
            h10n[idx] = dn; h6d[idx] = dd;
            h6n[idx] = xn; h9d[idx] = xd;
            idx++;
        end
        #1;
        cmp("R4", "B quo", qb, exp_q(an, ad, 8));
        cmp("R4", "B rem", rb, exp_r(an, ad, 8));
    endtask

    task automatic rstep(input string tag, input bit enable);
        step(tag, enable, $urandom % 256, $urandom % 256, $urandom % 1024,
             16 + ($urandom % 48), $urandom % 64, $urandom % 512);
    endtask

    // Clear held from the start: ranks at the outputs read zero.
    task automatic t_reset();
        #1 clr_n = 1'b0;
        repeat (3) @(negedge clk);
        cmp("R7", "C quo in clear", qc, 0);
        cmp("R7", "C rem in clear", rc, 0);
        clr_n = 1'b1;
        idx = 0;
    endtask

    // Back-to-back random operands on every enabled edge.
    task automatic t_random();
        for (int i = 0; i < 80; i++) rstep("R5", 1'b1);
    endtask

    // Edge operands, zero denominators and widest quotients.
    task automatic t_corner();
        step("R2", 1'b1, 255, 1, 1023, 16, 63, 1);
        step("R1", 1'b1, 0, 7, 0, 63, 0, 511);
        step("R1", 1'b1, 5, 200, 15, 63, 5, 300);
        step("R1", 1'b1, 255, 255, 1023, 63, 63, 63);
        step("R3", 1'b1, 200, 0, 500, 17, 45, 0);
        step("R3", 1'b1, 0, 0, 1, 16, 63, 0);
        step("R1", 1'b1, 128, 3, 777, 16, 40, 7);
        for (int i = 0; i < 8; i++) rstep("R1", 1'b1);
    endtask

    // Different rank placements across the instances under a fresh stream.
    task automatic t_place();
        for (int i = 0; i < 30; i++) rstep("R8", 1'b1);
    endtask

    // Denominators at the floor with large numerators.
    task automatic t_dmin();
        for (int i = 0; i < 20; i++)
            step("R9", 1'b1, $urandom % 256, $urandom % 256, 1023 - i * 7, 16 + (i % 4),
                 $urandom % 64, $urandom % 512);
        for (int i = 0; i < 8; i++) rstep("R9", 1'b1);
    endtask

    // The enable drops every third cycle while the operands keep changing.
    task automatic t_stall();
        for (int i = 0; i < 40; i++) rstep("R6", (i % 3) != 2);
        for (int i = 0; i < 8; i++) rstep("R6", 1'b1);
    endtask

    // Clear dropped between edges with results in flight, then a clean restart.
    task automatic t_clear();
        for (int i = 0; i < 10; i++) rstep("R7", 1'b1);
        #1 clr_n = 1'b0;
        #1;
        cmp("R7", "C quo after mid clear", qc, 0);
        cmp("R7", "C rem after mid clear", rc, 0);
        @(negedge clk);
        clr_n = 1'b1;
        idx = 0;
        for (int i = 0; i < 12; i++) rstep("R7", 1'b1);
    endtask

    initial begin : p_main
        t_reset();
        t_random();
        t_corner();
        t_place();
        t_dmin();
        t_stall();
        t_clear();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : p_watchdog
        #800000;
        checks++;
        errors++;
        $display("FAIL R5 watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule